// File: doc/BRIEF.md
# Power Management Event and Timer Block

This block holds the fixed power-management register set of a system controller. A small word-addressed register bus gives access to four things: a status register whose bits are cleared by writing one to them, an enable register, a control register, and a free-running power-management timer. The block raises a level-sensitive system control interrupt whenever an enabled status bit is pending. It also issues a one-cycle soft-off request when software writes the control register with suspend enable set and sleep type zero.

A separate two-byte power-management command port sits beside the register set. Two magic command values switch the interrupt-enable bit of the control register on and off. When the system-management configuration input is high, any write to the command byte also produces a one-cycle system management interrupt pulse. The timer advances on each cycle in which the tick-enable input is high. That input is meant to be driven at the nominal 3.579545 MHz timer rate. A power-button event input feeds the power-button status bit.

Top module: `pm_event_block`

## Requirements
- R1: The timer is TMR_W bits wide (default 24). It reset to zero and grows by one on every clock cycle with tickEn high, wrapping modulo 2^TMR_W. It is read at offset 0x08 as a 32-bit value whose bits above TMR_W read zero.
- R2: Status bit 0 (timer overflow) is set in the cycle where timer bit TMR_W-1 changes value, whether that change is 0 to 1 or 1 to 0.
- R3: A write to offset 0x00 clears each status bit whose written data bit is 1 and leaves bits written with 0 unchanged. A hardware set in the same cycle takes precedence over the clear. Status reads at 0x00 in bits 15:0.
- R4: The enable register at offset 0x02 stores the written 16 bits and reads them back. Bit 0 enables timer overflow, bit 5 the global event, bit 8 the power button and bit 10 the real-time clock.
- R5: sciOut is high exactly while at least one of status bits 0, 5, 8 or 10 is set together with the enable bit at the same position.
- R6: A cycle with pwrBtnEvt high sets status bit 8 only if enable bit 8 is set in that cycle. Otherwise it leaves status unchanged.
- R7: The control register at offset 0x04 stores the written 16 bits except bit 13, which always reads 0. A write with bit 13 = 1 and bits 11:10 = 00 makes softOffReq high for exactly the following cycle. With any other sleep type, no request is made.
- R8: Writing 0xF1 to the command byte sets control bit 0, and writing 0xF0 clears it. Other command values leave the control register unchanged. A command write in the same cycle as a control write is applied after it.
- R9: The command port decodes apmAddr: 0 selects the command byte and 1 selects the status byte. Each byte reads back on apmRdData as last written.
- R10: A write to the command byte while smiCfgEn is high makes smiPulse high for exactly the following cycle. No pulse is made when smiCfgEn is low or when the status byte is written.
- R11: Register reads at any offset other than 0x00, 0x02, 0x04 and 0x08 return zero. After reset, all registers and the timer are zero and sciOut, softOffReq and smiPulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer advance enable, one tick per high cycle |
| pwrBtnEvt | input | 1 | Power-button event |
| smiCfgEn | input | 1 | Configuration bit allowing SMI pulses |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWrData | input | 16 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| apmWrEn | input | 1 | Command port write strobe |
| apmAddr | input | 1 | Command port byte select |
| apmWrData | input | 8 | Command port write data |
| apmRdData | output | 8 | Command port read data for apmAddr |
| sciOut | output | 1 | System control interrupt level |
| softOffReq | output | 1 | One-cycle soft-off request |
| smiPulse | output | 1 | One-cycle system management interrupt |

## Verification
The checker assumes that the bus inputs are held stable across a clock edge and are never unknown while out of reset. It also assumes that a power-button event is judged against the enable value present in the same cycle. The bench changes every input only at the falling edge and keeps each write strobe high for exactly one rising edge. To keep runs short, it builds the block with a 10-bit timer. Because of that, the overflow is reached in both directions of the top-bit change within a few thousand ticks.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int REG_AW = 6;
  localparam int RD_W   = 32;
  localparam int HW     = 16;

  localparam logic [REG_AW-1:0] OFS_STS = 6'h00;
  localparam logic [REG_AW-1:0] OFS_EN  = 6'h02;
  localparam logic [REG_AW-1:0] OFS_CNT = 6'h04;
  localparam logic [REG_AW-1:0] OFS_TMR = 6'h08;

  localparam int BIT_TMR   = 0;
  localparam int BIT_GBL   = 5;
  localparam int BIT_PWR   = 8;
  localparam int BIT_RTC   = 10;
  localparam int BIT_SUSEN = 13;
  localparam int BIT_SCIEN = 0;

  localparam logic [HW-1:0] SCI_MASK =
    HW'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));

  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;

  typedef struct packed {
    logic stsWr;
    logic enWr;
    logic cntWr;
    logic apmCmdWr;
    logic apmStsWr;
    logic sciOn;
    logic sciOff;
    logic softOff;
    logic smi;
  } pmStrobe_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              wrSusEn,
  input  logic [1:0]        wrSlpTyp,
  input  logic              apmWrEn,
  input  logic              apmAddr,
  input  logic [7:0]        apmWrData,
  input  logic              smiCfgEn,
  output pmStrobe_t         strb
);
  logic cmdWr;

  always_comb begin
    cmdWr         = apmWrEn && (apmAddr == 1'b0);
    strb          = '0;
    strb.stsWr    = regWrEn && (regAddr == OFS_STS);
    strb.enWr     = regWrEn && (regAddr == OFS_EN);
    strb.cntWr    = regWrEn && (regAddr == OFS_CNT);
    strb.apmCmdWr = cmdWr;
    strb.apmStsWr = apmWrEn && (apmAddr == 1'b1);
    strb.sciOn    = cmdWr && (apmWrData == CMD_SCI_ON);
    strb.sciOff   = cmdWr && (apmWrData == CMD_SCI_OFF);
    strb.softOff  = strb.cntWr && wrSusEn && (wrSlpTyp == 2'b00);
    strb.smi      = cmdWr && smiCfgEn;
  end
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pmStrobe_t         strb,
  input  logic              tickEn,
  input  logic              pwrBtnEvt,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [HW-1:0]     regWrData,
  input  logic              apmAddr,
  input  logic [7:0]        apmWrData,
  output logic [RD_W-1:0]   regRdData,
  output logic [7:0]        apmRdData,
  output logic              sciOut,
  output logic              softOffReq,
  output logic              smiPulse,
  output logic [TMR_W-1:0]  timerVal,
  output logic [HW-1:0]     stsReg,
  output logic [HW-1:0]     enReg
);
  localparam int PAD_W = RD_W - TMR_W;
  localparam logic [HW-1:0] SUS_MASK = HW'(1 << BIT_SUSEN);

  logic [HW-1:0] cntReg;
  logic [HW-1:0] stsNext;
  logic [HW-1:0] cntNext;
  logic [7:0]    apmCmd;
  logic [7:0]    apmSts;
  logic          msbFlip;

  assign msbFlip = tickEn && (&timerVal[TMR_W-2:0]);

  always_comb begin
    stsNext = stsReg;
    if (strb.stsWr) stsNext = stsNext & ~regWrData;
    if (msbFlip) stsNext[BIT_TMR] = 1'b1;
    if (pwrBtnEvt && enReg[BIT_PWR]) stsNext[BIT_PWR] = 1'b1;
  end

  always_comb begin
    cntNext = cntReg;
    if (strb.cntWr) cntNext = regWrData & ~SUS_MASK;
    if (strb.sciOn) cntNext[BIT_SCIEN] = 1'b1;
    else if (strb.sciOff) cntNext[BIT_SCIEN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timerVal   <= '0;
      stsReg     <= '0;
      enReg      <= '0;
      cntReg     <= '0;
      apmCmd     <= '0;
      apmSts     <= '0;
      softOffReq <= 1'b0;
      smiPulse   <= 1'b0;
    end else begin
      if (tickEn) timerVal <= timerVal + 1'b1;
      stsReg <= stsNext;
      if (strb.enWr) enReg <= regWrData;
      cntReg <= cntNext;
      if (strb.apmCmdWr) apmCmd <= apmWrData;
      if (strb.apmStsWr) apmSts <= apmWrData;
      softOffReq <= strb.softOff;
      smiPulse   <= strb.smi;
    end
  end

  assign sciOut = |(stsReg & enReg & SCI_MASK);

  always_comb begin
    unique case (regAddr)
      OFS_STS: regRdData = {{(RD_W-HW){1'b0}}, stsReg};
      OFS_EN:  regRdData = {{(RD_W-HW){1'b0}}, enReg};
      OFS_CNT: regRdData = {{(RD_W-HW){1'b0}}, cntReg};
      OFS_TMR: regRdData = {{PAD_W{1'b0}}, timerVal};
      default: regRdData = '0;
    endcase
  end

  assign apmRdData = apmAddr ? apmSts : apmCmd;
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              pwrBtnEvt,
  input  logic              smiCfgEn,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [HW-1:0]     regWrData,
  output logic [RD_W-1:0]   regRdData,
  input  logic              apmWrEn,
  input  logic              apmAddr,
  input  logic [7:0]        apmWrData,
  output logic [7:0]        apmRdData,
  output logic              sciOut,
  output logic              softOffReq,
  output logic              smiPulse
);
  pmStrobe_t        strb;
  logic [TMR_W-1:0] timerVal;
  logic [HW-1:0]    stsReg;
  logic [HW-1:0]    enReg;

  pm_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrSusEn   (regWrData[BIT_SUSEN]),
    .wrSlpTyp  (regWrData[11:10]),
    .apmWrEn   (apmWrEn),
    .apmAddr   (apmAddr),
    .apmWrData (apmWrData),
    .smiCfgEn  (smiCfgEn),
    .strb      (strb)
  );

  pm_datapath #(.TMR_W(TMR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .tickEn     (tickEn),
    .pwrBtnEvt  (pwrBtnEvt),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .apmAddr    (apmAddr),
    .apmWrData  (apmWrData),
    .regRdData  (regRdData),
    .apmRdData  (apmRdData),
    .sciOut     (sciOut),
    .softOffReq (softOffReq),
    .smiPulse   (smiPulse),
    .timerVal   (timerVal),
    .stsReg     (stsReg),
    .enReg      (enReg)
  );
endmodule

// File: rtl/pm_event_block_chk.sv
module pm_event_block_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tickEn,
  input logic             pwrBtnEvt,
  input logic             smiCfgEn,
  input logic             regWrEn,
  input logic [5:0]       regAddr,
  input logic [15:0]      regWrData,
  input logic             apmWrEn,
  input logic             apmAddr,
  input logic             sciOut,
  input logic             softOffReq,
  input logic             smiPulse,
  input logic [TMR_W-1:0] timerVal,
  input logic [15:0]      stsReg,
  input logic [15:0]      enReg
);
  p_tmr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn |=> (timerVal == TMR_W'($past(timerVal) + 1'b1)));

  p_tmr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> $stable(timerVal));

  p_ovf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && (&timerVal[TMR_W-2:0])) |=> stsReg[0]);

  p_sci_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stsReg[8] && enReg[8]) |-> sciOut);

  p_pwr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enReg[8] && !stsReg[8]) |=> !stsReg[8]);

  p_pwr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrBtnEvt && enReg[8]) |=> stsReg[8]);

  p_softoff_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    softOffReq |-> $past(regWrEn && (regAddr == 6'h04) && regWrData[13]
                         && (regWrData[11:10] == 2'b00)));

  p_smi_make_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (apmWrEn && !apmAddr && smiCfgEn) |=> smiPulse);

  p_smi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smiPulse |-> $past(apmWrEn && !apmAddr && smiCfgEn));
endmodule

bind pm_event_block pm_event_block_chk #(.TMR_W(TMR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tickEn     (tickEn),
  .pwrBtnEvt  (pwrBtnEvt),
  .smiCfgEn   (smiCfgEn),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .apmWrEn    (apmWrEn),
  .apmAddr    (apmAddr),
  .sciOut     (sciOut),
  .softOffReq (softOffReq),
  .smiPulse   (smiPulse),
  .timerVal   (timerVal),
  .stsReg     (stsReg),
  .enReg      (enReg)
);

// File: tb/pm_event_block_tb.sv
module pm_event_block_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int TW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic        pwrBtnEvt = 1'b0;
  logic        smiCfgEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        apmWrEn = 1'b0;
  logic        apmAddr = 1'b0;
  logic [7:0]  apmWrData = '0;
  logic [7:0]  apmRdData;
  logic        sciOut;
  logic        softOffReq;
  logic        smiPulse;

  int checks = 0;
  int errors = 0;

  pm_event_block #(.TMR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .pwrBtnEvt(pwrBtnEvt),
    .smiCfgEn(smiCfgEn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .apmWrEn(apmWrEn),
    .apmAddr(apmAddr), .apmWrData(apmWrData), .apmRdData(apmRdData),
    .sciOut(sciOut), .softOffReq(softOffReq), .smiPulse(smiPulse)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    tickEn = 0; pwrBtnEvt = 0; smiCfgEn = 0; regWrEn = 0; apmWrEn = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic apmWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    apmAddr = a; apmWrData = d; apmWrEn = 1'b1;
    @(negedge clk);
    apmWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic tResetState();
    logic [31:0] d;
    doReset();
    regRead(6'h00, d); check("R11 sts reset", d, 0);
    regRead(6'h02, d); check("R11 en reset", d, 0);
    regRead(6'h04, d); check("R11 cnt reset", d, 0);
    regRead(6'h08, d); check("R11 tmr reset", d, 0);
    check("R11 sci reset", {31'b0, sciOut}, 0);
    check("R11 softoff reset", {31'b0, softOffReq}, 0);
    check("R11 smi reset", {31'b0, smiPulse}, 0);
    apmAddr = 0; #0.5; check("R11 apm cmd reset", {24'b0, apmRdData}, 0);
  endtask

  task automatic tTimer();
    logic [31:0] d;
    doReset();
    ticks(5);
    regRead(6'h08, d); check("R1 timer count 5", d, 5);
    repeat (3) @(negedge clk);
    regRead(6'h08, d); check("R1 timer holds without tick", d, 5);
    ticks((1 << TW) - 5);
    regRead(6'h08, d); check("R1 timer wraps to 0", d, 0);
    ticks(1000);
    regRead(6'h08, d); check("R1 upper bits zero", d, 1000);
  endtask

  task automatic tOverflow();
    logic [31:0] d;
    doReset();
    ticks((1 << (TW-1)) - 1);
    regRead(6'h00, d); check("R2 no overflow before msb change", d, 0);
    ticks(1);
    regRead(6'h00, d); check("R2 overflow on msb 0->1", d, 1);
    regWrite(6'h00, 16'h0000);
    regRead(6'h00, d); check("R3 write zero keeps status", d, 1);
    regWrite(6'h00, 16'hFFFE);
    regRead(6'h00, d); check("R3 write ones elsewhere keeps bit0", d, 1);
    regWrite(6'h00, 16'h0001);
    regRead(6'h00, d); check("R3 write one clears bit0", d, 0);
    regWrite(6'h02, 16'h0001);
    ticks((1 << (TW-1)) - 1);
    check("R5 sci low before overflow", {31'b0, sciOut}, 0);
    ticks(1);
    regRead(6'h00, d); check("R2 overflow on msb 1->0", d, 1);
    check("R5 sci on timer overflow", {31'b0, sciOut}, 1);
    regWrite(6'h02, 16'h0000);
    check("R5 sci low when enable cleared", {31'b0, sciOut}, 0);
  endtask

  task automatic tPwrBtn();
    logic [31:0] d;
    doReset();
    @(negedge clk); pwrBtnEvt = 1; @(negedge clk); pwrBtnEvt = 0;
    regRead(6'h00, d); check("R6 button ignored when disabled", d, 0);
    regWrite(6'h02, 16'h0521);
    regRead(6'h02, d); check("R4 enable readback", d, 32'h0521);
    check("R5 sci low with no status", {31'b0, sciOut}, 0);
    @(negedge clk); pwrBtnEvt = 1; @(negedge clk); pwrBtnEvt = 0;
    regRead(6'h00, d); check("R6 button sets bit8", d, 32'h0100);
    check("R5 sci on button", {31'b0, sciOut}, 1);
    regWrite(6'h00, 16'h0001);
    regRead(6'h00, d); check("R3 other bit write keeps bit8", d, 32'h0100);
    @(negedge clk);
    regAddr = 6'h00; regWrData = 16'h0100; regWrEn = 1; pwrBtnEvt = 1;
    @(negedge clk); regWrEn = 0; pwrBtnEvt = 0;
    regRead(6'h00, d); check("R3 set wins over clear", d, 32'h0100);
    regWrite(6'h00, 16'h0100);
    regRead(6'h00, d); check("R3 bit8 cleared", d, 0);
    check("R5 sci drops", {31'b0, sciOut}, 0);
    regWrite(6'h02, 16'h0021);
    @(negedge clk); pwrBtnEvt = 1; @(negedge clk); pwrBtnEvt = 0;
    regRead(6'h00, d); check("R6 button ignored without bit8 enable", d, 0);
  endtask

  task automatic tControl();
    logic [31:0] d;
    doReset();
    regWrite(6'h04, 16'h2C05);
    check("R7 no softoff with sleep type 3", {31'b0, softOffReq}, 0);
    regRead(6'h04, d); check("R7 bit13 not stored", d, 32'h0C05);
    regWrite(6'h04, 16'h2001);
    check("R7 softoff pulse", {31'b0, softOffReq}, 1);
    @(negedge clk);
    check("R7 softoff one cycle", {31'b0, softOffReq}, 0);
    regRead(6'h04, d); check("R7 readback after softoff", d, 32'h0001);
    regWrite(6'h04, 16'h0000);
    check("R7 no softoff without bit13", {31'b0, softOffReq}, 0);
  endtask

  task automatic tApm();
    logic [31:0] d;
    doReset();
    smiCfgEn = 1;
    apmWrite(1'b0, 8'hF1);
    check("R10 smi pulse on command", {31'b0, smiPulse}, 1);
    regRead(6'h04, d); check("R8 F1 sets sci enable", d, 1);
    @(negedge clk);
    check("R10 smi one cycle", {31'b0, smiPulse}, 0);
    apmWrite(1'b1, 8'h5A);
    check("R10 no smi on status byte", {31'b0, smiPulse}, 0);
    apmAddr = 1; #0.5; check("R9 status byte readback", {24'b0, apmRdData}, 8'h5A);
    apmAddr = 0; #0.5; check("R9 command byte readback", {24'b0, apmRdData}, 8'hF1);
    regWrite(6'h04, 16'h0C01);
    apmWrite(1'b0, 8'h77);
    regRead(6'h04, d); check("R8 other value leaves control", d, 32'h0C01);
    apmWrite(1'b0, 8'hF0);
    regRead(6'h04, d); check("R8 F0 clears sci enable", d, 32'h0C00);
    smiCfgEn = 0;
    apmWrite(1'b0, 8'h33);
    check("R10 no smi when config low", {31'b0, smiPulse}, 0);
    apmAddr = 0; #0.5; check("R9 command byte 0x33", {24'b0, apmRdData}, 8'h33);
    @(negedge clk);
    regAddr = 6'h04; regWrData = 16'h0000; regWrEn = 1;
    apmAddr = 0; apmWrData = 8'hF1; apmWrEn = 1;
    @(negedge clk); regWrEn = 0; apmWrEn = 0;
    regRead(6'h04, d); check("R8 command applied after control write", d, 1);
  endtask

  task automatic tUndecoded();
    logic [31:0] d;
    doReset();
    regWrite(6'h02, 16'hFFFF);
    regWrite(6'h04, 16'hFFFF);
    regRead(6'h06, d); check("R11 offset 0x06 zero", d, 0);
    regRead(6'h0C, d); check("R11 offset 0x0C zero", d, 0);
    regRead(6'h3F, d); check("R11 offset 0x3F zero", d, 0);
  endtask

  initial begin
    fork
      begin
        tResetState();
        tTimer();
        tOverflow();
        tPwrBtn();
        tControl();
        tApm();
        tUndecoded();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule